// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a sum-of-products programmable logic fabric. It receives the sum term that the array has built for the cell. It also receives an output-enable product term and two product terms shared by all cells: an asynchronous clear and a synchronous set. From these it produces a pin value with its enable, and a feedback signal in true and complemented form that is returned to the array.

A two-bit configuration word picks the cell's behaviour. One bit chooses whether the pin follows a D flip-flop or the sum term directly. The other bit chooses whether the pin is active-high or active-low.

The clear and set terms act on the flip-flop's stored state, not on the pin. The pin level that results from a clear therefore depends on the polarity bit. The source of the feedback also depends on the mode. A registered cell feeds back its inverted stored bit and ignores the pin. A combinatorial cell feeds back the pin level itself, so when its output is disabled the pin serves as an input.

Top module: `omc_macrocell`

## Requirements
- R1: `cfg_sel[1]` chooses the mode (0 = registered, 1 = combinatorial) and `cfg_sel[0]` chooses the polarity (1 = active-high, 0 = active-low); every other requirement uses this encoding.
- R2: In combinatorial mode the enabled pin value equals `sum_term` when active-high and its inverse when active-low, in the same cycle with no clock edge.
- R3: The flip-flop loads `sum_term` on every rising clock edge. In registered mode the enabled pin value equals the stored bit when active-high and its inverse when active-low.
- R4: `pad_oe` follows `oe_term`, and `pad_o` reads 0 whenever `pad_oe` is 0.
- R5: While `ar_term` is 1 the stored bit is 0 at once, without waiting for a clock edge, and it stays 0 after `ar_term` falls until the next rising edge.
- R6: When `sp_term` is 1 at a rising edge the stored bit becomes 1 at that edge. Raising `sp_term` between edges has no effect before the next edge.
- R7: When `ar_term` and `sp_term` are both 1, the stored bit is held at 0.
- R8: A cleared flip-flop gives a registered pin level of 0 when active-high and 1 when active-low.
- R9: In registered mode `fb_true` is the inverse of the stored bit, and `pad_i` has no effect on it.
- R10: In combinatorial mode `fb_true` is the pin level: `pad_o` while `pad_oe` is 1, and `pad_i` while `pad_oe` is 0.
- R11: `fb_comp` is always the complement of `fb_true`.
- R12: `rst_n` low clears the flip-flop at once. After `rst_n` rises, the flip-flop stays cleared through `SYNC_STAGES` rising edges and loads `sum_term` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flop and reset synchroniser |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| cfg_sel | input | 2 | Bit 1 mode (1 = combinatorial), bit 0 polarity (1 = active-high) |
| sum_term | input | 1 | Sum-of-products result for this cell |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| pad_i | input | 1 | Level seen on the pin from outside |
| pad_o | output | 1 | Pin drive value, 0 when disabled |
| pad_oe | output | 1 | Pin drive enable; high impedance when 0 |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complemented form |

## Verification
The only internal state is one stored bit, and it shows up in two places. In registered mode it appears on `pad_o`, after the polarity inversion, and on `fb_true`, inverted, in the cycle after the edge that loaded it. A bad clear, set or priority is therefore visible at the ports within one clock period, or within a fraction of a period for the asynchronous clear. Those cases are probed between edges as well as after them. A wrong reset-synchroniser depth shows up as the first loaded value arriving one edge early or late after reset release.

// File: rtl/omc_pkg.sv
package omc_pkg;

  localparam int unsigned CFG_W = 2;

  typedef enum logic {
    OMC_REGISTERED = 1'b0,
    OMC_COMB       = 1'b1
  } omc_mode_e;

  typedef struct packed {
    omc_mode_e mode;
    logic      active_high;
  } omc_cfg_t;

  function automatic omc_cfg_t omc_decode(input logic [CFG_W-1:0] raw);
    omc_cfg_t c;
    c.mode        = omc_mode_e'(raw[1]);
    c.active_high = raw[0];
    return c;
  endfunction

endpackage

// File: rtl/omc_rst_sync.sv
module omc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = (chain_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/omc_state_reg.sv
module omc_state_reg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic ar_term,
  input  logic sp_term,
  input  logic sum_term,
  output logic q_state
);

  logic clr_n;
  logic q_nxt;

  assign clr_n = rst_sync_n & ~ar_term;

  always_comb begin
    if (sp_term) begin
      q_nxt = 1'b1;
    end else begin
      q_nxt = sum_term;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q_state <= 1'b0;
    end else begin
      q_state <= q_nxt;
    end
  end

endmodule

// File: rtl/omc_pin_drive.sv
module omc_pin_drive
  import omc_pkg::*;
(
  input  omc_cfg_t cfg,
  input  logic     sum_term,
  input  logic     q_state,
  input  logic     oe_term,
  output logic     pad_o,
  output logic     pad_oe
);

  logic core_val;
  logic pol_val;

  always_comb begin
    if (cfg.mode == OMC_COMB) begin
      core_val = sum_term;
    end else begin
      core_val = q_state;
    end
    pol_val = cfg.active_high ? core_val : ~core_val;
  end

  assign pad_oe = oe_term;
  assign pad_o  = oe_term & pol_val;

endmodule

// File: rtl/omc_fb_select.sv
module omc_fb_select
  import omc_pkg::*;
(
  input  omc_cfg_t cfg,
  input  logic     q_state,
  input  logic     pad_o,
  input  logic     pad_oe,
  input  logic     pad_i,
  output logic     fb_true,
  output logic     fb_comp
);

  logic pin_level;

  always_comb begin
    pin_level = pad_oe ? pad_o : pad_i;
    if (cfg.mode == OMC_COMB) begin
      fb_true = pin_level;
    end else begin
      fb_true = ~q_state;
    end
  end

  assign fb_comp = ~fb_true;

endmodule

// File: rtl/omc_macrocell.sv
module omc_macrocell
  import omc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_sel,
  input  logic             sum_term,
  input  logic             oe_term,
  input  logic             ar_term,
  input  logic             sp_term,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             fb_true,
  output logic             fb_comp
);

  omc_cfg_t cfg;
  logic     rst_sync_n;
  logic     q_state;

  assign cfg = omc_decode(cfg_sel);

  omc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  omc_state_reg u_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .ar_term    (ar_term),
    .sp_term    (sp_term),
    .sum_term   (sum_term),
    .q_state    (q_state)
  );

  omc_pin_drive u_drive (
    .cfg      (cfg),
    .sum_term (sum_term),
    .q_state  (q_state),
    .oe_term  (oe_term),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe)
  );

  omc_fb_select u_fb (
    .cfg     (cfg),
    .q_state (q_state),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe),
    .pad_i   (pad_i),
    .fb_true (fb_true),
    .fb_comp (fb_comp)
  );

endmodule

// File: rtl/omc_macrocell_chk.sv
module omc_macrocell_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] cfg_sel,
  input logic       sum_term,
  input logic       oe_term,
  input logic       ar_term,
  input logic       sp_term,
  input logic       pad_i,
  input logic       pad_o,
  input logic       pad_oe,
  input logic       fb_true,
  input logic       fb_comp,
  input logic       q_state
);

  // R4
  oe_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pad_oe |-> !pad_o);

  // R2
  comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_sel[1] && oe_term) |-> (pad_o == (sum_term ~^ cfg_sel[0])));

  // R8
  clear_pin_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ar_term && !cfg_sel[1] && oe_term) |-> (pad_o == !cfg_sel[0]));

  // R6
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(sp_term) && $past(rst_sync_n) && !$past(ar_term) && !ar_term) |-> q_state);

  // R9
  reg_feedback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_sel[1] && pad_oe) |-> (fb_true == (pad_o ^ cfg_sel[0])));

  // R10
  comb_feedback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_sel[1] |-> (fb_true == (pad_oe ? pad_o : pad_i)));

  // R11
  fb_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fb_comp != fb_true);

endmodule

bind omc_macrocell omc_macrocell_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_sel    (cfg_sel),
  .sum_term   (sum_term),
  .oe_term    (oe_term),
  .ar_term    (ar_term),
  .sp_term    (sp_term),
  .pad_i      (pad_i),
  .pad_o      (pad_o),
  .pad_oe     (pad_oe),
  .fb_true    (fb_true),
  .fb_comp    (fb_comp),
  .q_state    (q_state)
);

// File: tb/omc_macrocell_tb.sv
module omc_macrocell_tb;

  localparam int unsigned CLK_PERIOD  = 10;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NVEC        = 14;

  // {cfg_sel[1:0], oe, sum, sp, pad_i, exp_pad_o, exp_fb_true}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b11_1_1_0_0_1_1,  // R2 comb active-high, R10 fb = pin
    8'b11_1_0_0_0_0_0,  // R2
    8'b11_0_1_0_1_0_1,  // R4 R10 disabled, fb = pad_i
    8'b11_0_1_0_0_0_0,  // R10
    8'b10_1_1_0_0_0_0,  // R2 comb active-low
    8'b10_1_0_0_0_1_1,  // R2
    8'b01_1_1_0_0_1_0,  // R3 reg active-high, R9 fb = ~q
    8'b01_1_0_0_0_0_1,  // R3
    8'b01_1_0_1_0_1_0,  // R6 set
    8'b01_0_1_0_1_0_0,  // R9 pad_i ignored, R4
    8'b00_1_1_0_0_0_0,  // R3 reg active-low
    8'b00_1_0_0_0_1_1,  // R3
    8'b00_1_0_1_0_0_0,  // R6
    8'b00_0_0_0_1_0_1   // R9 R4
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_sel;
  logic       sum_term, oe_term, ar_term, sp_term, pad_i;
  logic       pad_o, pad_oe, fb_true, fb_comp;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omc_macrocell #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_sel  (cfg_sel),
    .sum_term (sum_term),
    .oe_term  (oe_term),
    .ar_term  (ar_term),
    .sp_term  (sp_term),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe),
    .fb_true  (fb_true),
    .fb_comp  (fb_comp)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; cfg_sel = 2'b01; sum_term = 1'b0; oe_term = 1'b1;
    ar_term = 1'b0; sp_term = 1'b0; pad_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12 R8 reset state, active-high
    chk("R12", "pad_o in reset", pad_o, 1'b0);
    chk("R9", "fb_true in reset", fb_true, 1'b1);
    chk("R11", "fb_comp in reset", fb_comp, 1'b0);
    cfg_sel = 2'b00;
    #1;
    chk("R8", "pad_o cleared active-low", pad_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SYNC_STAGES + 2) @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      cfg_sel  = VEC[i][7:6];
      oe_term  = VEC[i][5];
      sum_term = VEC[i][4];
      sp_term  = VEC[i][3];
      pad_i    = VEC[i][2];
      @(negedge clk);
      chk("R1", $sformatf("vec %0d pad_o", i), pad_o, VEC[i][1]);
      chk("R4", $sformatf("vec %0d pad_oe", i), pad_oe, VEC[i][5]);
      chk("R10", $sformatf("vec %0d fb_true", i), fb_true, VEC[i][0]);
      chk("R11", $sformatf("vec %0d fb_comp", i), fb_comp, ~VEC[i][0]);
    end
    sp_term = 1'b0;

    // R5 R8 asynchronous clear between edges
    cfg_sel = 2'b01; oe_term = 1'b1; sum_term = 1'b1; pad_i = 1'b0;
    @(negedge clk);
    chk("R3", "loaded one", pad_o, 1'b1);
    #2 ar_term = 1'b1;
    #1 chk("R5", "clear without edge", pad_o, 1'b0);
    ar_term = 1'b0;
    #1 chk("R5", "clear holds until edge", pad_o, 1'b0);
    cfg_sel = 2'b00;
    #0.5 chk("R8", "cleared pin active-low", pad_o, 1'b1);
    @(negedge clk);

    // R6 set waits for edge
    cfg_sel = 2'b01; sum_term = 1'b0;
    @(negedge clk);
    chk("R3", "loaded zero", pad_o, 1'b0);
    #1 sp_term = 1'b1;
    #2 chk("R6", "set not before edge", pad_o, 1'b0);
    @(negedge clk);
    chk("R6", "set at edge", pad_o, 1'b1);
    sp_term = 1'b0;

    // R7 clear beats set
    ar_term = 1'b1; sp_term = 1'b1; sum_term = 1'b1;
    @(negedge clk);
    chk("R7", "clear wins", pad_o, 1'b0);
    @(negedge clk);
    chk("R7", "clear wins again", pad_o, 1'b0);
    chk("R9", "fb while cleared", fb_true, 1'b1);
    ar_term = 1'b0; sum_term = 1'b0;
    @(negedge clk);
    chk("R6", "set after clear drops", pad_o, 1'b1);
    sp_term = 1'b0;

    // R12 async reset and synchronised release
    sum_term = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R12", "reset clears at once", pad_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < SYNC_STAGES; k++) begin
      @(negedge clk);
      chk("R12", $sformatf("held after release edge %0d", k + 1), pad_o, 1'b0);
    end
    @(negedge clk);
    chk("R12", "first load after release", pad_o, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule